// File: doc/BRIEF.md
# Frequency Select Arbiter with Watchdog Fallback

This block decides which frequency setting drives a clock synthesizer's dividers. Four candidates compete: the frequency-select pins sampled once after power-on reset, a code held in a software control register, raw divider words that software programs directly, and a safe code that a seconds-based watchdog forces when the system stops servicing it. The block reports the winning source, the active 4-bit code, whether the dividers follow the raw words, and a sticky watchdog status flag.

Software reaches the block through a single-cycle register write port. The register index carries meaning. Index 0 is the main control register. Index 9 holds the watchdog timeout in seconds. Index 10 holds the watchdog control bits and the divider-mode bit. Indices 11 and 12 hold the low and high divider words. A one-cycle `sec_tick` pulse marks each elapsed second. A one-cycle `alive_kick` pulse marks that the system is healthy.

The watchdog is a three-state machine. In state OFF the counter reloads every cycle. The ARM transition goes to RUN when enable is set. The DISARM transition goes from RUN back to OFF when enable is cleared. The EXPIRE transition goes from RUN to FIRED when a tick takes the count from 1 to 0. The ACK transition goes from FIRED to OFF when software writes index 10 with the status bit at 0.

Top module: `freq_sel_wdog`

## Requirements
- R1: On the first rising clock edge after `rst_n` is released, the block samples `fs_pins` into an internal latch. Later changes on `fs_pins` have no effect on the outputs.
- R2: After reset, the register contents are: index 0 = 0x00, index 9 = 16, index 10 = 0x00, indices 11 and 12 = 0x00. The outputs are `freq_src`=0 (pins), `div_mode`=0, `wdt_fired`=0 and `freq_code`= the latched pins.
- R3: Source selection when the watchdog has not fired works as follows.
  - Index 10 bit 7 = 1 gives `freq_src`=2 with `div_mode`=1.
  - Otherwise, index 0 bit 0 = 1 gives `freq_src`=1.
  - Otherwise `freq_src`=0.
  - `freq_code` is index 0 bits [7:4] when index 0 bit 0 = 1, and the latched pins when it is 0.
  - `div_lo` and `div_hi` always show indices 11 and 12.
- R4: While enabled (index 10 bit 6), the watchdog counter decrements once per `sec_tick`. With a timeout of N, the N-th tick after arming sets `wdt_fired`, and tick N-1 does not.
- R5: The counter reloads from index 9 in three cases: on `alive_kick`, on any write to index 9 (using the new value), and continuously while disabled. When `alive_kick` and `sec_tick` arrive in the same cycle, the reload wins.
- R6: A timeout value of 0 behaves as 1 second.
- R7: While `wdt_fired` is 1, the outputs are forced: `freq_src`=3, `freq_code`= index 10 bits [3:0], and `div_mode`=0. This holds whatever index 10 bit 7 and index 0 say.
- R8: `wdt_fired` stays set until software writes index 10 with bit 5 = 0, or until reset. The following do not clear it: disabling the watchdog, sending kicks, and writing bit 5 = 1. Writing bit 5 = 1 while the watchdog has not fired does not set it.
- R9: Writes to indices other than 0, 9, 10, 11 and 12 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| fs_pins | input | 4 | Frequency-select pin levels |
| cfg_we | input | 1 | Register write strobe, one cycle |
| cfg_addr | input | 5 | Register index |
| cfg_wdata | input | 8 | Register write data |
| sec_tick | input | 1 | One-second tick pulse |
| alive_kick | input | 1 | System-alive service pulse |
| freq_code | output | 4 | Active frequency code |
| freq_src | output | 2 | Winning source: 0 pins, 1 register, 2 divider, 3 safe |
| div_mode | output | 1 | Dividers follow the raw divider words |
| div_lo | output | 8 | Low divider word (index 11) |
| div_hi | output | 8 | High divider word (index 12) |
| wdt_fired | output | 1 | Sticky watchdog expiry status |

## Verification
Two watchdog events can land on the same clock edge: a service kick and a one-second tick that would otherwise take the count from 1 to 0. The bench brings the count to 1 and then drives both pulses in one cycle. It judges the result by expiry timing: the flag must stay low, and the full timeout must then elapse again before it rises. The same timing method is used on a write to the timeout register that lands while the count is at 1.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int REG_W  = 8;
    localparam int CODE_W = 4;
    localparam int ADDR_W = 5;

    // register indices
    localparam logic [ADDR_W-1:0] IX_MAIN  = 5'd0;
    localparam logic [ADDR_W-1:0] IX_WTIME = 5'd9;
    localparam logic [ADDR_W-1:0] IX_WCTRL = 5'd10;
    localparam logic [ADDR_W-1:0] IX_DIVLO = 5'd11;

    // field positions
    localparam int MAIN_SEL_BIT  = 0;
    localparam int MAIN_CODE_LSB = 4;
    localparam int WC_DIV_BIT    = 7;
    localparam int WC_EN_BIT     = 6;
    localparam int WC_STAT_BIT   = 5;
    localparam int WC_SAFE_LSB   = 0;

    typedef enum logic [1:0] {
        SRC_PINS = 2'd0,
        SRC_REG  = 2'd1,
        SRC_DIV  = 2'd2,
        SRC_SAFE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_RUN   = 2'd1,
        WD_FIRED = 2'd2
    } wd_e;

endpackage

// File: rtl/fsel_regs.sv
module fsel_regs
    import fsel_pkg::*;
#(
    parameter int              P_REG_W   = REG_W,
    parameter int              P_CODE_W  = CODE_W,
    parameter int              P_ADDR_W  = ADDR_W,
    parameter logic [7:0]      WTIME_RST = 8'd16,
    parameter int              N_DIV     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_CODE_W-1:0] fs_pins,
    input  logic                we,
    input  logic [P_ADDR_W-1:0] addr,
    input  logic [P_REG_W-1:0]  wdata,
    output logic [P_CODE_W-1:0] fs_lat,
    output logic                sw_sel,
    output logic [P_CODE_W-1:0] sw_code,
    output logic [P_REG_W-1:0]  wtime,
    output logic                wd_en,
    output logic                div_sel,
    output logic [P_CODE_W-1:0] safe_code,
    output logic [P_REG_W-1:0]  div_word [N_DIV],
    output logic                wr_wtime,
    output logic                stat_clr
);

    logic cap_done;
    logic hit_main, hit_wtime, hit_wctrl;

    assign hit_main  = we && (addr == IX_MAIN);
    assign hit_wtime = we && (addr == IX_WTIME);
    assign hit_wctrl = we && (addr == IX_WCTRL);

    assign wr_wtime = hit_wtime;
    assign stat_clr = hit_wctrl && !wdata[WC_STAT_BIT];

    // one-shot capture of the select pins after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_done <= 1'b0;
            fs_lat   <= '0;
        end else if (!cap_done) begin
            cap_done <= 1'b1;
            fs_lat   <= fs_pins;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_sel  <= 1'b0;
            sw_code <= '0;
        end else if (hit_main) begin
            sw_sel  <= wdata[MAIN_SEL_BIT];
            sw_code <= wdata[MAIN_CODE_LSB +: P_CODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wtime <= P_REG_W'(WTIME_RST);
        end else if (hit_wtime) begin
            wtime <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_en     <= 1'b0;
            div_sel   <= 1'b0;
            safe_code <= '0;
        end else if (hit_wctrl) begin
            wd_en     <= wdata[WC_EN_BIT];
            div_sel   <= wdata[WC_DIV_BIT];
            safe_code <= wdata[WC_SAFE_LSB +: P_CODE_W];
        end
    end

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        localparam logic [P_ADDR_W-1:0] IX = P_ADDR_W'(int'(IX_DIVLO) + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                div_word[g] <= '0;
            end else if (we && (addr == IX)) begin
                div_word[g] <= wdata;
            end
        end
    end

    AST_PINS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> $stable(fs_lat)); // R1

endmodule

// File: rtl/fsel_wdt.sv
module fsel_wdt
    import fsel_pkg::*;
#(
    parameter int P_REG_W = REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               kick,
    input  logic               wr_wtime,
    input  logic [P_REG_W-1:0] wtime_new,
    input  logic [P_REG_W-1:0] wtime_q,
    input  logic               stat_clr,
    output logic               fired
);

    localparam logic [P_REG_W-1:0] ONE = P_REG_W'(1);

    wd_e               state_q, state_d;
    logic [P_REG_W-1:0] cnt_q, cnt_d;
    logic [P_REG_W-1:0] reload_src, reload_val;
    logic               reload_req;

    assign reload_src = wr_wtime ? wtime_new : wtime_q;
    assign reload_val = (reload_src == '0) ? ONE : reload_src;
    assign reload_req = kick || wr_wtime;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    // next state: ARM, DISARM, EXPIRE, ACK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:   if (en) state_d = WD_RUN;
            WD_RUN: begin
                if (!en)
                    state_d = WD_OFF;
                else if (!reload_req && tick && (cnt_q == ONE))
                    state_d = WD_FIRED;
            end
            WD_FIRED: if (stat_clr) state_d = WD_OFF;
            default:  state_d = WD_OFF;
        endcase
    end

    // counter
    always_comb begin
        cnt_d = cnt_q;
        unique case (state_q)
            WD_OFF: cnt_d = reload_val;
            WD_RUN: begin
                if (!en || reload_req) cnt_d = reload_val;
                else if (tick)         cnt_d = cnt_q - ONE;
            end
            WD_FIRED: if (stat_clr) cnt_d = reload_val;
            default:  cnt_d = reload_val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ONE;
        else        cnt_q <= cnt_d;
    end

    // outputs
    always_comb begin
        fired = (state_q == WD_FIRED);
    end

    AST_ZERO_ONLY_FIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> (state_q == WD_FIRED)); // R4
    AST_NO_ZERO_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WD_FIRED) |-> (cnt_q != '0)); // R6
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN && en && tick && !kick && !wr_wtime)
        |=> (cnt_q == $past(cnt_q) - ONE)); // R4
    AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN && en && kick) |=> (cnt_q == $past(reload_val))); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_FIRED && !stat_clr) |=> (state_q == WD_FIRED)); // R8

endmodule

// File: rtl/fsel_mux.sv
module fsel_mux
    import fsel_pkg::*;
#(
    parameter int P_CODE_W = CODE_W
) (
    input  logic                fired,
    input  logic                div_sel,
    input  logic                sw_sel,
    input  logic [P_CODE_W-1:0] sw_code,
    input  logic [P_CODE_W-1:0] fs_lat,
    input  logic [P_CODE_W-1:0] safe_code,
    output src_e                src,
    output logic [P_CODE_W-1:0] code,
    output logic                div_mode
);

    logic [P_CODE_W-1:0] base_code;

    assign base_code = sw_sel ? sw_code : fs_lat;

    always_comb begin
        src      = SRC_PINS;
        code     = base_code;
        div_mode = 1'b0;
        if (fired) begin
            src  = SRC_SAFE;
            code = safe_code;
        end else if (div_sel) begin
            src      = SRC_DIV;
            div_mode = 1'b1;
        end else if (sw_sel) begin
            src = SRC_REG;
        end
    end

endmodule

// File: rtl/freq_sel_wdog.sv
module freq_sel_wdog
    import fsel_pkg::*;
#(
    parameter int         P_REG_W   = REG_W,
    parameter int         P_CODE_W  = CODE_W,
    parameter int         P_ADDR_W  = ADDR_W,
    parameter logic [7:0] WTIME_RST = 8'd16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_CODE_W-1:0] fs_pins,
    input  logic                cfg_we,
    input  logic [P_ADDR_W-1:0] cfg_addr,
    input  logic [P_REG_W-1:0]  cfg_wdata,
    input  logic                sec_tick,
    input  logic                alive_kick,
    output logic [P_CODE_W-1:0] freq_code,
    output logic [1:0]          freq_src,
    output logic                div_mode,
    output logic [P_REG_W-1:0]  div_lo,
    output logic [P_REG_W-1:0]  div_hi,
    output logic                wdt_fired
);

    localparam int N_DIV = 2;

    logic [P_CODE_W-1:0] fs_lat, sw_code, safe_code;
    logic                sw_sel, wd_en, div_sel, wr_wtime, stat_clr;
    logic [P_REG_W-1:0]  wtime;
    logic [P_REG_W-1:0]  div_word [N_DIV];
    src_e                src;

    fsel_regs #(
        .P_REG_W(P_REG_W), .P_CODE_W(P_CODE_W), .P_ADDR_W(P_ADDR_W),
        .WTIME_RST(WTIME_RST), .N_DIV(N_DIV)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .fs_pins(fs_pins),
        .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .fs_lat(fs_lat), .sw_sel(sw_sel), .sw_code(sw_code),
        .wtime(wtime), .wd_en(wd_en), .div_sel(div_sel),
        .safe_code(safe_code), .div_word(div_word),
        .wr_wtime(wr_wtime), .stat_clr(stat_clr)
    );

    fsel_wdt #(.P_REG_W(P_REG_W)) u_wdt (
        .clk(clk), .rst_n(rst_n), .en(wd_en), .tick(sec_tick),
        .kick(alive_kick), .wr_wtime(wr_wtime), .wtime_new(cfg_wdata),
        .wtime_q(wtime), .stat_clr(stat_clr), .fired(wdt_fired)
    );

    fsel_mux #(.P_CODE_W(P_CODE_W)) u_mux (
        .fired(wdt_fired), .div_sel(div_sel), .sw_sel(sw_sel),
        .sw_code(sw_code), .fs_lat(fs_lat), .safe_code(safe_code),
        .src(src), .code(freq_code), .div_mode(div_mode)
    );

    assign freq_src = src;
    assign div_lo   = div_word[0];
    assign div_hi   = div_word[1];

    AST_SAFE_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_fired |-> (freq_src == SRC_SAFE && !div_mode)); // R7
    AST_DIV_ONLY_DIVSRC: assert property (@(posedge clk) disable iff (!rst_n)
        div_mode |-> (freq_src == SRC_DIV)); // R3

endmodule

// File: tb/freq_sel_wdog_tb.sv
`timescale 1ns/1ps
module freq_sel_wdog_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fs_pins = 4'hA;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       sec_tick = 1'b0;
    logic       alive_kick = 1'b0;
    logic [3:0] freq_code;
    logic [1:0] freq_src;
    logic       div_mode;
    logic [7:0] div_lo, div_hi;
    logic       wdt_fired;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    freq_sel_wdog u_dut (
        .clk(clk), .rst_n(rst_n), .fs_pins(fs_pins),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .sec_tick(sec_tick), .alive_kick(alive_kick),
        .freq_code(freq_code), .freq_src(freq_src), .div_mode(div_mode),
        .div_lo(div_lo), .div_hi(div_hi), .wdt_fired(wdt_fired)
    );

    // vectors: index0 value, index10 value, expected src, div_mode, code
    localparam int NV = 6;
    localparam logic [7:0] V_MAIN [NV] = '{8'h00, 8'h31, 8'h30, 8'h31, 8'h00, 8'hF1};
    localparam logic [7:0] V_WC   [NV] = '{8'h00, 8'h00, 8'h00, 8'h80, 8'h85, 8'h07};
    localparam logic [1:0] V_SRC  [NV] = '{2'd0, 2'd1, 2'd0, 2'd2, 2'd2, 2'd1};
    localparam logic       V_DIV  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [3:0] V_CODE [NV] = '{4'hA, 4'h3, 4'hA, 4'h3, 4'hA, 4'hF};

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input bit t, input bit k);
        @(negedge clk);
        sec_tick = t; alive_kick = k;
        @(negedge clk);
        sec_tick = 1'b0; alive_kick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog timeout got=0 exp=1");
            finish_run();
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        fs_pins = 4'h5;              // R1: change after capture
        idle(2);
        chk("R1 latched pins", freq_code, 4'hA);
        chk("R2 reset src", freq_src, 0);
        chk("R2 reset div_mode", div_mode, 0);
        chk("R2 reset fired", wdt_fired, 0);
        chk("R2 reset div_lo", div_lo, 0);
        chk("R2 reset div_hi", div_hi, 0);

        // R2/R4: default timeout of 16 seconds
        wr(5'd10, 8'h40);
        idle(2);
        for (int i = 0; i < 15; i++) pulse(1, 0);
        chk("R4 default 15 ticks", wdt_fired, 0);
        pulse(1, 0);
        chk("R4 default 16th tick", wdt_fired, 1);
        chk("R7 safe src", freq_src, 3);
        wr(5'd10, 8'h00);
        chk("R8 cleared", wdt_fired, 0);

        // R3: vector table
        for (int v = 0; v < NV; v++) begin
            wr(5'd0, V_MAIN[v]);
            wr(5'd10, V_WC[v]);
            chk($sformatf("R3 vec%0d src", v), freq_src, V_SRC[v]);
            chk($sformatf("R3 vec%0d div", v), div_mode, V_DIV[v]);
            chk($sformatf("R3 vec%0d code", v), freq_code, V_CODE[v]);
        end

        // R9: unused indices
        wr(5'd5, 8'hFF);
        wr(5'd13, 8'hFF);
        wr(5'd31, 8'hFF);
        chk("R9 src unchanged", freq_src, 1);
        chk("R9 code unchanged", freq_code, 4'hF);
        chk("R9 div unchanged", div_lo, 0);
        wr(5'd11, 8'h12);
        wr(5'd12, 8'h34);
        chk("R3 div_lo", div_lo, 8'h12);
        chk("R3 div_hi", div_hi, 8'h34);

        // R4/R5: timeout 3, kick and tick together at count 1
        wr(5'd9, 8'd3);
        wr(5'd10, 8'h4C);
        idle(2);
        pulse(1, 0); pulse(1, 0);
        chk("R4 two ticks", wdt_fired, 0);
        pulse(1, 1);
        chk("R5 kick beats tick", wdt_fired, 0);
        pulse(1, 0); pulse(1, 0);
        chk("R5 reloaded to 3", wdt_fired, 0);
        pulse(1, 0);
        chk("R4 third tick", wdt_fired, 1);
        chk("R7 safe code", freq_code, 4'hC);
        pulse(0, 1);
        chk("R8 kick ignored", wdt_fired, 1);
        wr(5'd10, 8'h2C);
        chk("R8 disable keeps", wdt_fired, 1);
        wr(5'd10, 8'h6C);
        chk("R8 write one keeps", wdt_fired, 1);
        wr(5'd10, 8'hEC);
        chk("R7 div suppressed", div_mode, 0);
        chk("R7 src safe w/div", freq_src, 3);
        wr(5'd10, 8'hCC);
        chk("R8 ack clears", wdt_fired, 0);
        chk("R3 div after ack", freq_src, 2);
        wr(5'd10, 8'h4C);
        idle(1);

        // R5: write to timeout while count is 1
        pulse(1, 0); pulse(1, 0);
        wr(5'd9, 8'd2);
        pulse(1, 0);
        chk("R5 write reload", wdt_fired, 0);
        pulse(1, 0);
        chk("R5 fires on new value", wdt_fired, 1);

        // R6: timeout of zero
        wr(5'd9, 8'd0);
        wr(5'd10, 8'h4C);
        idle(2);
        pulse(1, 0);
        chk("R6 zero is one second", wdt_fired, 1);

        // R5: disabled counter does not run
        wr(5'd10, 8'h0C);
        for (int i = 0; i < 5; i++) pulse(1, 0);
        chk("R5 disabled no fire", wdt_fired, 0);
        wr(5'd10, 8'h6C);
        idle(2);
        chk("R8 write one no set", wdt_fired, 0);
        pulse(1, 0);
        chk("R6 after enable", wdt_fired, 1);

        done = 1'b1;
        finish_run();
    end

endmodule